// File: doc/BRIEF.md
# Accumulator Processor with Selectable Operand Addressing

This block is a small multicycle processor built around an accumulator and an index register. It runs programs held in an internal synchronous single-port memory of 16-bit words. Each instruction moves through a fixed chain of register transfers, one per clock. The fetch puts the program counter into the memory address register, waits one cycle for the read, and copies the returned word into the instruction register. What happens after that depends on the opcode and on a three-bit mode field in the instruction word.

The mode field chooses how the operand is obtained:
- Immediate: the 9-bit field itself, taken as a signed value, is the operand.
- Direct: the field is the operand address.
- Relative: the operand address is the field added to the current instruction's address.
- Indirect: one extra memory read fetches a pointer, and the pointer is the operand address.
- Indexed: the operand address is the field plus the index register.

The index register can be loaded, decremented and tested by a branch. A counting loop over a table therefore needs only three instructions per element.

Programs are written through a load port, and only while reset is held. Once reset is released the processor starts at address 0. It runs until it reaches a halt instruction or an illegal encoding. It then freezes and signals completion, and an illegal encoding also raises an error flag. Results leave through an output register that carries a one-cycle valid pulse.

Top module: `accum_cpu`

## Requirements
- R1: While `rst` is high, `pc`, `out_valid`, `done` and `error` are 0, and a high `ld_we` writes `ld_data` to word `ld_addr`. While `rst` is low, the load port has no effect on memory.
- R2: An instruction word is opcode in bits [15:12], mode in [11:9] and field in [8:0]. The opcodes are: 0 halt, 1 load A, 2 add to A, 3 subtract from A, 4 store A, 5 load X, 6 decrement X, 7 branch if X non-negative, 8 output A. Each instruction is fetched from the word at the program counter and latched in the instruction register before it is decoded.
- R3: Mode 0 (direct) uses the field as the operand address. Mode 1 (immediate) uses the field, sign-extended to 16 bits, as the operand and makes no operand read.
- R4: Mode 2 (relative) forms the operand address as (address of the executing instruction + signed field) modulo 512.
- R5: Mode 3 (indirect) reads the word at the field address and uses its low 9 bits as the operand address, or as the branch target.
- R6: Mode 4 (indexed) forms the operand address as (field + low 9 bits of X) modulo 512.
- R7: Load A, add and subtract (A minus operand) update A modulo 2^16. Load X writes X. Store writes A to the operand address.
- R8: Decrement X subtracts 1 from X modulo 2^16. The branch moves the program counter to the effective address when bit 15 of X is 0, and to the next word otherwise. Neither reads an operand.
- R9: Output copies A to `out_data` and raises `out_valid` for exactly one cycle.
- R10: Halt raises `done`, which stays high until reset. `pc` holds the halt instruction's address, and no further instruction executes.
- R11: Store or branch with mode 1, a mode code of 5 to 7 on an opcode that uses a mode, or an opcode above 8, stops the processor with `done` and `error` both high. `pc` holds that instruction's address, and no memory write takes place.
- R12: An instruction that makes no operand read takes 4 cycles, a store takes 5, and an operand read takes 6. Indirect mode adds 2 cycles. `done` rises on the 4th cycle of the halt instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; enables the load port |
| ld_we | input | 1 | Load port write strobe (honoured only in reset) |
| ld_addr | input | 9 | Load port word address |
| ld_data | input | 16 | Load port write data |
| out_data | output | 16 | Value written by the output instruction |
| out_valid | output | 1 | One-cycle strobe marking a new `out_data` |
| done | output | 1 | Processor has stopped |
| error | output | 1 | Processor stopped on an illegal encoding |
| pc | output | 9 | Program counter |

## Verification
The assertions assume that `rst` is held for at least one clock before a program runs and that the memory image is complete before `rst` falls. They place no constraint on the program contents, because every encoding, including the illegal ones, has a defined outcome. The stimulus loads each program under reset and then releases reset. Throughout one run it drives the load port with a conflicting write, which a correct design must ignore. Each program ends in a halt or an illegal word, so no run depends on memory words that were never loaded.

// File: rtl/acpu_pkg.sv
package acpu_pkg;
  localparam int unsigned OPC_W  = 4;
  localparam int unsigned MODE_W = 3;

  // opcode values (R2)
  localparam logic [OPC_W-1:0] OP_HALT = 4'd0;
  localparam logic [OPC_W-1:0] OP_LDA  = 4'd1;
  localparam logic [OPC_W-1:0] OP_ADD  = 4'd2;
  localparam logic [OPC_W-1:0] OP_SUB  = 4'd3;
  localparam logic [OPC_W-1:0] OP_STA  = 4'd4;
  localparam logic [OPC_W-1:0] OP_LDX  = 4'd5;
  localparam logic [OPC_W-1:0] OP_DECX = 4'd6;
  localparam logic [OPC_W-1:0] OP_BRPX = 4'd7;
  localparam logic [OPC_W-1:0] OP_OUT  = 4'd8;

  // operand access modes (R3..R6)
  localparam logic [MODE_W-1:0] MD_DIR = 3'd0;
  localparam logic [MODE_W-1:0] MD_IMM = 3'd1;
  localparam logic [MODE_W-1:0] MD_REL = 3'd2;
  localparam logic [MODE_W-1:0] MD_IND = 3'd3;
  localparam logic [MODE_W-1:0] MD_IDX = 3'd4;

  typedef enum logic [3:0] {
    S_FETCH,   // PC -> MAR
    S_FWAIT,   // memory read in flight
    S_LOADIR,  // MDR -> IR
    S_DECODE,  // decode, immediate / register work, address launch
    S_IWAIT,   // pointer read in flight
    S_IADDR,   // pointer -> MAR
    S_OWAIT,   // operand read in flight
    S_EXEC,    // operand -> A / X, PC + 1
    S_STORE,   // A -> memory, PC + 1
    S_HALT
  } state_e;
endpackage

// File: rtl/acpu_mem.sv
module acpu_mem #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store_q [DEPTH];

  // single port, read-before-write, one cycle read latency
  always_ff @(posedge clk) begin
    if (we) store_q[addr] <= wdata;
    rdata <= store_q[addr];
  end
endmodule

// File: rtl/acpu_agen.sv
module acpu_agen
  import acpu_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [ADDR_W-1:0] field,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] xlo,
  output logic [ADDR_W-1:0] ea
);
  // field is two's complement for relative offsets: modulo add gives the sign
  always_comb begin
    case (mode)
      MD_REL:  ea = pc + field;   // R4
      MD_IDX:  ea = field + xlo;  // R6
      default: ea = field;        // direct, and the pointer address for indirect
    endcase
  end
endmodule

// File: rtl/acpu_ctrl.sv
module acpu_ctrl
  import acpu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] mdr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] pc
);
  localparam int unsigned MODE_LO = ADDR_W;
  localparam int unsigned OPC_LO  = ADDR_W + MODE_W;
  localparam int unsigned SEXT_W  = DATA_W - ADDR_W;

  state_e              state;
  logic [ADDR_W-1:0]   mar;
  logic [DATA_W-1:0]   ir, acc, xr;

  logic [OPC_W-1:0]    op;
  logic [MODE_W-1:0]   mode;
  logic [ADDR_W-1:0]   field, ea, tgt;
  logic [DATA_W-1:0]   imm, opnd, acc_nx, xr_nx;
  logic                op_known, mode_known, mode_op, illegal, launch;

  assign op    = ir[OPC_LO +: OPC_W];
  assign mode  = ir[MODE_LO +: MODE_W];
  assign field = ir[ADDR_W-1:0];
  assign imm   = {{SEXT_W{field[ADDR_W-1]}}, field};  // R3 sign extension

  acpu_agen #(.ADDR_W(ADDR_W)) u_agen (
    .mode  (mode),
    .field (field),
    .pc    (pc),
    .xlo   (xr[ADDR_W-1:0]),
    .ea    (ea)
  );

  // decode (R2, R11)
  always_comb begin
    op_known   = (op <= OP_OUT);
    mode_known = (mode <= MD_IDX);
    mode_op    = (op == OP_LDA) || (op == OP_ADD) || (op == OP_SUB) ||
                 (op == OP_STA) || (op == OP_LDX) || (op == OP_BRPX);
    illegal    = !op_known ||
                 (mode_op && (!mode_known ||
                  (mode == MD_IMM && (op == OP_STA || op == OP_BRPX))));
    launch     = (state == S_IADDR) ||
                 (state == S_DECODE && !illegal && mode_op &&
                  mode != MD_IMM && mode != MD_IND);
    tgt        = (state == S_IADDR) ? mdr[ADDR_W-1:0] : ea;  // R5 pointer
  end

  // accumulator / index update (R7, R8)
  always_comb begin
    opnd   = (state == S_EXEC) ? mdr : imm;
    acc_nx = acc;
    xr_nx  = xr;
    case (op)
      OP_LDA:  acc_nx = opnd;
      OP_ADD:  acc_nx = acc + opnd;
      OP_SUB:  acc_nx = acc - opnd;
      OP_LDX:  xr_nx  = opnd;
      OP_DECX: xr_nx  = xr - 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_FETCH;
      pc        <= '0;
      mar       <= '0;
      ir        <= '0;
      acc       <= '0;
      xr        <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (launch) begin
        if (op == OP_BRPX) begin
          pc    <= xr[DATA_W-1] ? pc + 1'b1 : tgt;  // R8
          state <= S_FETCH;
        end else begin
          mar   <= tgt;
          state <= (op == OP_STA) ? S_STORE : S_OWAIT;
        end
      end else begin
        case (state)
          S_FETCH: begin
            mar   <= pc;
            state <= S_FWAIT;
          end
          S_FWAIT:  state <= S_LOADIR;
          S_LOADIR: begin
            ir    <= mdr;
            state <= S_DECODE;
          end
          S_DECODE: begin
            if (illegal) begin
              err   <= 1'b1;
              done  <= 1'b1;
              state <= S_HALT;
            end else if (op == OP_HALT) begin
              done  <= 1'b1;
              state <= S_HALT;
            end else if (op == OP_OUT) begin
              out_data  <= acc;
              out_valid <= 1'b1;
              pc        <= pc + 1'b1;
              state     <= S_FETCH;
            end else if (op == OP_DECX || mode == MD_IMM) begin
              acc   <= acc_nx;
              xr    <= xr_nx;
              pc    <= pc + 1'b1;
              state <= S_FETCH;
            end else begin
              mar   <= field;  // indirect: fetch the pointer
              state <= S_IWAIT;
            end
          end
          S_IWAIT: state <= S_IADDR;
          S_OWAIT: state <= S_EXEC;
          S_EXEC: begin
            acc   <= acc_nx;
            xr    <= xr_nx;
            pc    <= pc + 1'b1;
            state <= S_FETCH;
          end
          S_STORE: begin
            pc    <= pc + 1'b1;
            state <= S_FETCH;
          end
          default: state <= S_HALT;
        endcase
      end
    end
  end

  assign mem_addr  = mar;
  assign mem_we    = (state == S_STORE);
  assign mem_wdata = acc;

  // ---------------- assertions ----------------
  assert_ir_load_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_DECODE) |-> (ir == $past(mdr)));

  assert_imm_noread_R3: assert property (@(posedge clk) disable iff (rst)
    (state == S_DECODE && !illegal && mode_op && mode == MD_IMM) |=> (state == S_FETCH));

  assert_decx_R8: assert property (@(posedge clk) disable iff (rst)
    (state == S_DECODE && op == OP_DECX) |=> (xr == $past(xr) - 1'b1));

  assert_out_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_halt_hold_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && $stable(pc) && !out_valid));

  assert_err_done_R11: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  assert_store_legal_R11: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (op == OP_STA && mode != MD_IMM && mode <= MD_IDX && !done));
endmodule

// File: rtl/accum_cpu.sv
module accum_cpu #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              done,
  output logic              error,
  output logic [ADDR_W-1:0] pc
);
  logic [ADDR_W-1:0] core_addr, m_addr;
  logic [DATA_W-1:0] core_wdata, m_wdata, m_rdata;
  logic              core_we, m_we;

  // the load port owns the memory port only during reset (R1)
  assign m_addr  = rst ? ld_addr : core_addr;
  assign m_we    = rst ? ld_we   : core_we;
  assign m_wdata = rst ? ld_data : core_wdata;

  acpu_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .we    (m_we),
    .addr  (m_addr),
    .wdata (m_wdata),
    .rdata (m_rdata)
  );

  acpu_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .mdr       (m_rdata),
    .mem_addr  (core_addr),
    .mem_we    (core_we),
    .mem_wdata (core_wdata),
    .out_data  (out_data),
    .out_valid (out_valid),
    .done      (done),
    .err       (error),
    .pc        (pc)
  );
endmodule

// File: tb/sim_accum_cpu.sv
module sim_accum_cpu;
  localparam int DW = 16;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic [DW-1:0] out_data;
  logic          out_valid, done, error;
  logic [AW-1:0] pc;

  int n_chk = 0;
  int n_fail = 0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #5 clk = ~clk;

  accum_cpu #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .out_data(out_data), .out_valid(out_valid), .done(done), .error(error), .pc(pc)
  );

  function automatic logic [DW-1:0] enc(input logic [3:0] op, input logic [2:0] md,
                                        input logic [AW-1:0] f);
    return {op, md, f};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic expect_out(input logic [DW-1:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected output", int'(out_data), 0);
      end else begin
        automatic logic [DW-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(out_data == e, t, int'(out_data), int'(e));
      end
    end
  end

  task automatic put(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = AW'(a); ld_data = d;
  endtask

  task automatic clear_mem();
    rst = 1'b1;
    for (int a = 0; a < (1 << AW); a++) put(a, '0);
  endtask

  task automatic run(input int maxc, output int cyc);
    @(negedge clk);
    ld_we = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    while (!done && cyc < maxc) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    if (!done) check(1'b0, "watchdog expired", cyc, maxc);
  endtask

  task automatic settle_and_close(input string tag, input int exp_pc, input bit exp_err);
    automatic logic [AW-1:0] pc0 = pc;
    repeat (20) @(negedge clk);
    check(done == 1'b1, {tag, " R10 done held"}, int'(done), 1);
    check(pc == pc0 && pc == AW'(exp_pc), {tag, " R10/R11 pc frozen"}, int'(pc), exp_pc);
    check(error == exp_err, {tag, " R11 error flag"}, int'(error), int'(exp_err));
    check(exp_q.size() == 0, {tag, " R9 outputs missing"}, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "global watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    int tbl[8] = '{3, 14, 15, 92, 65, 35, 89, 79};
    int sum = 0;

    // ---------- R1 reset state ----------
    repeat (3) @(negedge clk);
    check(pc == '0, "R1 pc in reset", int'(pc), 0);
    check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    check(done == 1'b0, "R1 done in reset", int'(done), 0);
    check(error == 1'b0, "R1 error in reset", int'(error), 0);

    // ---------- program A: indexed summing loop (R6, R8, R12, R1 ignore) ----------
    clear_mem();
    put(0, enc(4'd1, 3'd1, 9'd0));    // LDA #0
    put(1, enc(4'd5, 3'd0, 9'd20));   // LDX 20
    put(2, enc(4'd2, 3'd4, 9'd40));   // ADD 40+X
    put(3, enc(4'd6, 3'd0, 9'd0));    // DECX
    put(4, enc(4'd7, 3'd0, 9'd2));    // BRPX 2
    put(5, enc(4'd8, 3'd0, 9'd0));    // OUT
    put(6, enc(4'd0, 3'd0, 9'd0));    // HALT
    put(20, 16'd7);
    for (int i = 0; i < 8; i++) begin
      put(40 + i, DW'(tbl[i]));
      sum += tbl[i];
    end
    expect_out(DW'(sum), "R6 indexed loop total");
    @(negedge clk);
    ld_we = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    // R1: load port driven during the run must not alter the table
    ld_we = 1'b1; ld_addr = 9'd45; ld_data = 16'd999;
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    ld_we = 1'b0;
    if (!done) check(1'b0, "watchdog expired", cyc, 2000);
    check(cyc == 130, "R12 loop program cycle count", cyc, 130);
    settle_and_close("A", 6, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(done == 1'b0 && pc == '0, "R1 reset clears done and pc", int'(pc), 0);

    // ---------- program B: each mode, store, branch both ways ----------
    clear_mem();
    put(0,  enc(4'd1, 3'd1, 9'h1FB));  // LDA #-5
    put(1,  enc(4'd8, 3'd0, 9'd0));
    put(2,  enc(4'd2, 3'd2, 9'd30));   // ADD rel +30 -> 32
    put(3,  enc(4'd8, 3'd0, 9'd0));
    put(4,  enc(4'd3, 3'd3, 9'd33));   // SUB ind [33] -> 34
    put(5,  enc(4'd8, 3'd0, 9'd0));
    put(6,  enc(4'd4, 3'd0, 9'd35));   // STA 35
    put(7,  enc(4'd1, 3'd1, 9'd0));    // LDA #0
    put(8,  enc(4'd1, 3'd0, 9'd35));   // LDA 35
    put(9,  enc(4'd8, 3'd0, 9'd0));
    put(10, enc(4'd2, 3'd2, 9'h1F6));  // ADD rel -10 -> 0
    put(11, enc(4'd8, 3'd0, 9'd0));
    put(12, enc(4'd5, 3'd1, 9'd1));    // LDX #1
    put(13, enc(4'd6, 3'd0, 9'd0));
    put(14, enc(4'd6, 3'd0, 9'd0));    // X = -1
    put(15, enc(4'd7, 3'd0, 9'd40));   // not taken
    put(16, enc(4'd8, 3'd0, 9'd0));
    put(17, enc(4'd5, 3'd1, 9'd3));    // LDX #3
    put(18, enc(4'd1, 3'd4, 9'h1FC));  // LDA 508+3 -> 511
    put(19, enc(4'd8, 3'd0, 9'd0));
    put(20, enc(4'd7, 3'd3, 9'd36));   // BRPX via [36] -> 23, taken
    put(21, enc(4'd8, 3'd0, 9'd0));
    put(22, enc(4'd0, 3'd0, 9'd0));
    put(23, enc(4'd3, 3'd1, 9'd4));    // SUB #4
    put(24, enc(4'd8, 3'd0, 9'd0));
    put(25, enc(4'd0, 3'd0, 9'd0));
    put(32, 16'd100);
    put(33, 16'd34);
    put(34, 16'd15);
    put(36, 16'd23);
    put(511, 16'h1234);
    expect_out(16'hFFFB, "R3 immediate sign extension");
    expect_out(16'h005F, "R4 relative forward operand");
    expect_out(16'h0050, "R5 indirect subtract");
    expect_out(16'h0050, "R7 store then direct load");
    expect_out(16'h144B, "R4 relative backward operand");
    expect_out(16'h144B, "R8 branch not taken on negative X");
    expect_out(16'h1234, "R6 indexed address wraps");
    expect_out(16'h1230, "R8 indirect branch taken");
    run(2000, cyc);
    settle_and_close("B", 25, 1'b0);

    // ---------- program C: store immediate is illegal (R11) ----------
    clear_mem();
    put(0, enc(4'd1, 3'd1, 9'd7));
    put(1, enc(4'd8, 3'd0, 9'd0));
    put(2, enc(4'd4, 3'd1, 9'd10));   // STA # -> error stop
    put(3, enc(4'd8, 3'd0, 9'd0));
    expect_out(16'd7, "R11 output before illegal store");
    run(2000, cyc);
    settle_and_close("C R11", 2, 1'b1);

    // ---------- program D: undefined opcode (R11) ----------
    clear_mem();
    put(0, enc(4'd8, 3'd0, 9'd0));
    put(1, enc(4'd15, 3'd0, 9'd0));
    put(2, enc(4'd8, 3'd0, 9'd0));
    expect_out(16'd0, "R9 output of reset accumulator");
    run(2000, cyc);
    settle_and_close("D R11", 1, 1'b1);

    // ---------- program E: undefined mode code (R11) ----------
    clear_mem();
    put(0, enc(4'd2, 3'd5, 9'd0));
    put(1, enc(4'd8, 3'd0, 9'd0));
    run(2000, cyc);
    check(cyc == 4, "R12 stop on illegal mode after decode", cyc, 4);
    settle_and_close("E R11", 0, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule